// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block turns a fast reference clock into the 16x oversampling tick that a UART transmitter and receiver step on. The division ratio has a 16-bit integer part N and a 4-bit fraction F, both in units of reference cycles. The generator never produces a fractional period directly. It mixes periods of N and N+1 cycles so that any 16 consecutive ticks span exactly 16N+F reference cycles. The baud rate is therefore the reference frequency divided by 16(N+F/16). At 16 MHz, N=8 and F=11 give about 115108 baud, and N=1 with F=0 gives 1 Mbaud.

Software loads the integer part one byte at a time and the fraction through its own strobe. Every load restarts the divider from a clean state, so the line never sees a period built from a mix of old and new settings. A second output divides the tick stream by the oversampling ratio and gives one enable per serial bit.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the integer part and the fraction are both zero, and neither tick16_o nor bit_en_o is asserted.
- R2: With F=0 and N≥1, tick16_o rises every N reference cycles.
- R3: With N≥1, any 16 consecutive ticks after a restart span exactly 16N+F reference cycles, measured from the first tick to the seventeenth.
- R4: Every gap between two successive ticks is N or N+1 cycles. The long gaps follow the carry of a 4-bit accumulator that adds F on each tick, starting from zero.
- R5: A write is captured on a clock edge, and the cycle after that edge carries no tick. The first tick is asserted in the cycle that begins N edges after the capturing edge.
- R6: While N=0, no tick and no bit enable are produced, and the counters stay cleared.
- R7: A write to any divisor register, even in the middle of a period and even with an unchanged value, clears the accumulator and restarts timing as in R5.
- R8: When N≥2, each tick lasts exactly one reference cycle.
- R9: bit_en_o is asserted only together with tick16_o, on the 16th, 32nd and each later 16th tick after a restart.
- R10: div_byte_wr[1] loads wr_data into integer bits 15:8. div_byte_wr[0] loads wr_data into integer bits 7:0. div_frac_wr loads wr_data[3:0] as the fraction and ignores wr_data[7:4].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_byte_wr | input | 2 | Byte write strobes for the integer part (bit 1 high byte, bit 0 low byte) |
| div_frac_wr | input | 1 | Write strobe for the fraction |
| wr_data | input | 8 | Write data shared by all strobes |
| tick16_o | output | 1 | Oversampling tick, one reference cycle wide |
| bit_en_o | output | 1 | One-per-bit enable, coincident with every 16th tick |

## Verification
The bench drives several settings and measures how far apart the ticks land. It uses a pure integer divide, a coarse fraction at a small N, the extremes N=1 with F=0 and F=1, and a large N.

A design that mishandles the carry would show a 16-tick span that is off by one or more cycles. A design that misses the clear on write would start a rewritten stream with a long period, or with its bit-enable phase shifted. A design that only gates the output at N=0 would release a stray tick when counting resumes. The bench also loads the fraction with junk in the upper data bits and loads the two integer bytes separately, to expose swapped or mis-sliced register fields.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  // Default geometry of the divider
  localparam int FBG_INT_W  = 16;
  localparam int FBG_FRAC_W = 4;
  localparam int FBG_BYTE_W = 8;
  localparam int FBG_OSR    = 16;
endpackage

// File: rtl/fbg_div_regs.sv
module fbg_div_regs #(
  parameter int INT_W  = fbg_pkg::FBG_INT_W,
  parameter int FRAC_W = fbg_pkg::FBG_FRAC_W,
  parameter int BYTE_W = fbg_pkg::FBG_BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [INT_W/BYTE_W-1:0]   byte_wr,
  input  logic                      frac_wr,
  input  logic [BYTE_W-1:0]         wr_data,
  output logic [INT_W-1:0]          int_div,
  output logic [FRAC_W-1:0]         frac_div,
  output logic                      reload_o
);
  localparam int NB = INT_W / BYTE_W;

  // any divisor write, seen as one event
  logic any_wr;
  assign any_wr = (|byte_wr) | frac_wr;

  for (genvar gi = 0; gi < NB; gi++) begin : g_byte
    logic [BYTE_W-1:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n)           b_q <= '0;
      else if (byte_wr[gi]) b_q <= wr_data;
    end
    assign int_div[gi*BYTE_W +: BYTE_W] = b_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frac_div <= '0;
      reload_o <= 1'b0;
    end else begin
      if (frac_wr) frac_div <= wr_data[FRAC_W-1:0];
      reload_o <= any_wr;
    end
  end

  p_write_reloads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> reload_o);
  p_frac_low_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frac_wr |=> frac_div == $past(wr_data[FRAC_W-1:0]));
  p_low_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_wr[0] |=> int_div[BYTE_W-1:0] == $past(wr_data));
endmodule

// File: rtl/fbg_tick_core.sv
module fbg_tick_core #(
  parameter int INT_W  = fbg_pkg::FBG_INT_W,
  parameter int FRAC_W = fbg_pkg::FBG_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_div,
  input  logic [FRAC_W-1:0] frac_div,
  input  logic              reload_i,
  output logic              tick_o,
  output logic              run_o
);
  localparam int CW = INT_W + 1;
  localparam int AW = FRAC_W + 1;

  // length of the current period: N, or N+1 after an accumulator carry
  function automatic logic [CW-1:0] period_len(input logic [INT_W-1:0] n, input logic lng);
    return {1'b0, n} + {{INT_W{1'b0}}, lng};
  endfunction

  // accumulator step: {carry, new phase}
  function automatic logic [AW-1:0] acc_step(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] f);
    return {1'b0, a} + {1'b0, f};
  endfunction

  logic [CW-1:0]     cnt_q;
  logic [CW-1:0]     cur_len;
  logic [FRAC_W-1:0] acc_q;
  logic              long_q;
  logic [AW-1:0]     acc_next;
  logic              period_end;

  assign run_o      = |int_div;
  assign cur_len    = period_len(int_div, long_q);
  assign period_end = (cnt_q + CW'(1)) == cur_len;
  assign acc_next   = acc_step(acc_q, frac_div);
  assign tick_o     = run_o && !reload_i && period_end;

  always_ff @(posedge clk) begin
    if (!rst_n || reload_i || !run_o) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      long_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q  <= '0;
      acc_q  <= acc_next[FRAC_W-1:0];
      long_q <= acc_next[FRAC_W];
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_i |-> cnt_q <= {1'b0, int_div});
  p_acc_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> (cnt_q == '0 && acc_q == '0 && !long_q));
  p_long_needs_frac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (long_q && !reload_i) |-> frac_div != '0);
  p_single_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && int_div > INT_W'(1)) |=> !tick_o);
  p_idle_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_o && !reload_i) |=> cnt_q == '0);
endmodule

// File: rtl/fbg_bit_div.sv
module fbg_bit_div #(
  parameter int OSR    = fbg_pkg::FBG_OSR,
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clear_i,
  output logic bit_en_o
);
  localparam int SW = (OSR > 1) ? $clog2(OSR) : 1;

  if (ENABLE) begin : g_on
    logic [SW-1:0] sub_q;
    logic          sub_last;
    assign sub_last = sub_q == SW'(OSR - 1);
    assign bit_en_o = tick_i && sub_last;

    always_ff @(posedge clk) begin
      if (!rst_n || clear_i) sub_q <= '0;
      else if (tick_i)       sub_q <= sub_last ? '0 : sub_q + SW'(1);
    end

    p_bit_with_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en_o |-> tick_i);
    p_sub_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clear_i) |=> $stable(sub_q));
    p_sub_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> sub_q == '0);
  end else begin : g_off
    assign bit_en_o = 1'b0;
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int INT_W  = fbg_pkg::FBG_INT_W,
  parameter int FRAC_W = fbg_pkg::FBG_FRAC_W,
  parameter int BYTE_W = fbg_pkg::FBG_BYTE_W,
  parameter int OSR    = fbg_pkg::FBG_OSR,
  parameter bit BIT_EN = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [INT_W/BYTE_W-1:0] div_byte_wr,
  input  logic                    div_frac_wr,
  input  logic [BYTE_W-1:0]       wr_data,
  output logic                    tick16_o,
  output logic                    bit_en_o
);
  logic [INT_W-1:0]  int_div;
  logic [FRAC_W-1:0] frac_div;
  logic              reload;
  logic              run;
  logic              sub_clear;

  fbg_div_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W), .BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .byte_wr(div_byte_wr), .frac_wr(div_frac_wr),
    .wr_data(wr_data), .int_div(int_div), .frac_div(frac_div), .reload_o(reload)
  );

  fbg_tick_core #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .int_div(int_div), .frac_div(frac_div),
    .reload_i(reload), .tick_o(tick16_o), .run_o(run)
  );

  assign sub_clear = reload || !run;

  fbg_bit_div #(.OSR(OSR), .ENABLE(BIT_EN)) u_bit (
    .clk(clk), .rst_n(rst_n), .tick_i(tick16_o), .clear_i(sub_clear),
    .bit_en_o(bit_en_o)
  );

  p_no_tick_on_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|div_byte_wr || div_frac_wr) |-> !tick16_o);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!tick16_o && !bit_en_o));
endmodule

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] div_byte_wr = '0;
  logic       div_frac_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tick16_o, bit_en_o;

  always #5 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .div_byte_wr(div_byte_wr), .div_frac_wr(div_frac_wr),
    .wr_data(wr_data), .tick16_o(tick16_o), .bit_en_o(bit_en_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int tq[$];
  int bq[$];
  int w_cyc = 0;

  // behavioural reference: divisor values, pending restart, cycles left, tick index
  int m_n = 0, m_f = 0, m_left = 0, m_k = 0, m_sub = 0;
  bit m_rel = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_n = 0; m_f = 0; m_rel = 0; m_left = 0; m_k = 0; m_sub = 0;
    end else if (|div_byte_wr || div_frac_wr) begin
      if (div_byte_wr[0]) m_n = (m_n & 32'hFF00) | int'(wr_data);
      if (div_byte_wr[1]) m_n = (m_n & 32'h00FF) | (int'(wr_data) << 8);
      if (div_frac_wr)    m_f = int'(wr_data) % 16;
      m_rel = 1;
    end else if (m_rel) begin
      m_rel = 0; m_k = 0; m_sub = 0; m_left = m_n;
    end else if (m_n == 0) begin
      m_left = 0;
    end else if (m_left == 1) begin
      m_k = m_k + 1;
      m_sub = (m_sub + 1) % 16;
      m_left = m_n + (m_k * m_f) / 16 - ((m_k - 1) * m_f) / 16;
    end else begin
      m_left = m_left - 1;
    end
  end

  // compare against the reference in the middle of every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      bit et, eb;
      et = !m_rel && m_n != 0 && m_left == 1;
      eb = et && m_sub == 15;
      check(tick16_o == et, "R4 per-cycle tick", int'(tick16_o), int'(et));
      check(bit_en_o == eb, "R9 per-cycle bit_en", int'(bit_en_o), int'(eb));
      if (tick16_o) tq.push_back(cyc);
      if (bit_en_o) bq.push_back(cyc);
    end
  end

  task automatic wr(input logic [1:0] bsel, input logic fsel, input logic [7:0] d);
    div_byte_wr = bsel; div_frac_wr = fsel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    div_byte_wr = '0; div_frac_wr = 1'b0; wr_data = '0;
  endtask

  task automatic restart_log();
    w_cyc = cyc;
    tq.delete();
    bq.delete();
  endtask

  task automatic prog(input int n, input int f);
    wr(2'b01, 1'b0, 8'(n & 255));
    wr(2'b10, 1'b0, 8'(n >> 8));
    wr(2'b00, 1'b1, 8'(f));
    restart_log();
  endtask

  task automatic wait_ticks(input int k);
    while (tq.size() < k) @(negedge clk);
  endtask

  task automatic check_span(input int n, input int f, input string tag);
    check(tq[16] - tq[0] == 16 * n + f, tag, tq[16] - tq[0], 16 * n + f);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", tq.size(), 17);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing after reset
    begin
      int seen = 0;
      repeat (20) begin @(negedge clk); seen += int'(tick16_o) + int'(bit_en_o); end
      check(seen == 0, "R1 reset quiet", seen, 0);
    end

    // R2 / R5: integer divide
    prog(8, 0);
    wait_ticks(17);
    check(tq[0] - w_cyc == 8, "R5 first tick latency", tq[0] - w_cyc, 8);
    for (int i = 1; i < 17; i++)
      check(tq[i] - tq[i-1] == 8, "R2 integer gap", tq[i] - tq[i-1], 8);
    check_span(8, 0, "R3 span N=8 F=0");

    // R3 / R4 / R8 / R9: N=8 F=11
    prog(8, 11);
    wait_ticks(33);
    check_span(8, 11, "R3 span N=8 F=11");
    begin
      int longs = 0;
      for (int i = 1; i < 17; i++) begin
        check(tq[i] - tq[i-1] == 8 || tq[i] - tq[i-1] == 9, "R4 gap N or N+1", tq[i] - tq[i-1], 8);
        check(tq[i] - tq[i-1] >= 2, "R8 single-cycle tick", tq[i] - tq[i-1], 2);
        if (tq[i] - tq[i-1] == 9) longs++;
      end
      check(longs == 11, "R4 long gap count", longs, 11);
    end
    check(bq.size() == 2, "R9 bit_en count", bq.size(), 2);
    if (bq.size() == 2) begin
      check(bq[0] == tq[15], "R9 first bit_en", bq[0], tq[15]);
      check(bq[1] == tq[31], "R9 second bit_en", bq[1], tq[31]);
    end

    // extremes of N
    prog(1, 0);
    wait_ticks(17);
    check_span(1, 0, "R2 span N=1 F=0");
    prog(1, 1);
    wait_ticks(17);
    check_span(1, 1, "R3 span N=1 F=1");
    prog(833, 5);
    wait_ticks(17);
    check_span(833, 5, "R3 span N=833 F=5");

    // R6: N=0 stops everything
    prog(0, 9);
    repeat (300) @(negedge clk);
    check(tq.size() == 0, "R6 no tick at N=0", tq.size(), 0);
    check(bq.size() == 0, "R6 no bit_en at N=0", bq.size(), 0);

    // R7: rewrite mid-stream with the same fraction
    prog(5, 7);
    wait_ticks(7);
    repeat (2) @(negedge clk);
    wr(2'b00, 1'b1, 8'h77);
    restart_log();
    wait_ticks(17);
    check(tq[0] - w_cyc == 5, "R7 restart latency", tq[0] - w_cyc, 5);
    check_span(5, 7, "R7 span after rewrite");
    check(bq.size() == 1 && bq[0] == tq[15], "R7 bit phase restarted", bq.size() > 0 ? bq[0] : -1, tq[15]);

    // R10: byte mapping and ignored upper fraction bits
    wr(2'b10, 1'b0, 8'h01);
    wr(2'b01, 1'b0, 8'h02);
    wr(2'b00, 1'b1, 8'hF3);
    restart_log();
    wait_ticks(17);
    check(tq[0] - w_cyc == 258, "R10 integer byte mapping", tq[0] - w_cyc, 258);
    check_span(258, 3, "R10 fraction low bits only");

    summary();
  end
endmodule